// File: doc/BRIEF.md
# IDE PIO strobe timing generator

This block paces programmed-I/O transfers on one IDE/ATA channel. A requester hands it one transfer at a time: direction, target device, register address, chip selects and, for writes, the data word. The block then plays out the bus cycle in three phases. In the setup phase the address and chip selects are valid and both strobes are high. In the active phase the active-low read or write strobe is low. In the recovery phase the strobe is high again and no new transfer may start. On a read, the data word present on the bus is captured as the strobe rises and is handed back with a one-cycle valid pulse.

The length of each phase comes from a 32-bit timing word. The word has one half per device, and the target device of each transfer picks the half that governs it. A plain write port loads the word. A new value is used only by transfers accepted after the write. A transfer already running keeps the values it started with. Every count is in clock cycles, and a zero count still gives a phase of one clock.

Top module: `ide_pio_strobe_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it, busy is 0, req_ready is 1, both strobes and both chip-select outputs are high (ide_cs_n = 2'b11), ide_dout_en is 0 and rsp_valid is 0.
- R2: The timing word resets to 0x62DD62DD. This gives either device a setup count of 6, an active count of 11 and a recovery count of 29. Device 1 takes setup from bits [31:28], active from [27:22] and recovery from [21:16]. Device 0 uses bits [15:12], [11:6] and [5:0] in the same way.
- R3: After the edge that accepts a request, the setup phase lasts S cycles with the address and chip selects valid and both strobes high. The selected strobe is then low for A cycles. Recovery follows for R cycles with the strobe high. S, A and R are the counts of the selected device.
- R4: req_dev = 0 selects the device 0 half of the timing word and req_dev = 1 selects the device 1 half, for each transfer on its own.
- R5: A count field of zero gives a phase of exactly one cycle.
- R6: On a read (req_write = 0), ide_din is sampled at the edge that ends the active phase. It appears on rsp_data with rsp_valid high for exactly one cycle, the first recovery cycle. Writes give no rsp_valid.
- R7: On a write (req_write = 1), ide_dout carries req_wdata and ide_dout_en is high during the setup and active phases only. ide_dout_en stays low for reads.
- R8: busy is high from the cycle after acceptance through the last recovery cycle, and req_ready equals the inverse of busy. A request held valid while busy is accepted in the first idle cycle.
- R9: A timing-word write changes only transfers accepted at edges after the write edge. A transfer already in progress keeps its original phase lengths.
- R10: The address and the chip selects (ide_cs_n = inverted req_cs) stay constant from setup through recovery. A read drives only ide_rd_n low and a write drives only ide_wr_n low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Load the timing word |
| cfg_wr_data | input | 32 | New timing word |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 1 | Target device, picks the timing half |
| req_addr | input | 3 | Task-file register address |
| req_cs | input | 2 | Active-high chip-select pattern |
| req_wdata | input | 16 | Write data word |
| busy | output | 1 | Transfer in progress including recovery |
| ide_addr | output | 3 | Bus address |
| ide_cs_n | output | 2 | Active-low chip selects |
| ide_rd_n | output | 1 | Active-low read strobe |
| ide_wr_n | output | 1 | Active-low write strobe |
| ide_dout | output | 16 | Bus write data |
| ide_dout_en | output | 1 | Write data drive enable |
| ide_din | input | 16 | Bus read data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | 16 | Captured read data |

## Verification
The hardest case to reach is a timing-word write that lands while a transfer is partway through its setup phase. The bench issues a read under the reset timing and, two cycles into setup, writes a very different word. It then measures every phase of that read against the old counts and every phase of the next read against the new ones. The read capture edge is checked in a similar way: the bench changes ide_din as soon as it sees the strobe high again, so a capture one cycle late returns the wrong word.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

    // Field widths of one device half of the timing word
    localparam int SETUP_W  = 4;
    localparam int ACTIVE_W = 6;
    localparam int RECOV_W  = 6;
    localparam int HALF_W   = SETUP_W + ACTIVE_W + RECOV_W;
    localparam int NUM_DEV  = 2;
    localparam int REG_W    = NUM_DEV * HALF_W;
    localparam int DEV_W    = $clog2(NUM_DEV);

    // Phase counter must hold the widest field
    localparam int CNT_W = (SETUP_W > ACTIVE_W)
                         ? ((SETUP_W > RECOV_W) ? SETUP_W : RECOV_W)
                         : ((ACTIVE_W > RECOV_W) ? ACTIVE_W : RECOV_W);

    localparam logic [REG_W-1:0] TIMING_RESET = 32'h62DD_62DD;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_RECOV  = 2'd3
    } phase_e;

    // Packed MSB-first so it overlays one half of the timing word
    typedef struct packed {
        logic [SETUP_W-1:0]  setup;
        logic [ACTIVE_W-1:0] active;
        logic [RECOV_W-1:0]  recov;
    } dev_timing_t;

    // Counter load value for a phase: length minus one, zero counts as one
    function automatic logic [CNT_W-1:0] phase_load(input logic [CNT_W-1:0] count);
        return (count == '0) ? '0 : count - 1'b1;
    endfunction

endpackage

// File: rtl/ide_pio_timing_reg.sv
module ide_pio_timing_reg
    import ide_pio_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [REG_W-1:0]            wr_data,
    output dev_timing_t [NUM_DEV-1:0]   dev_tim
);

    logic [REG_W-1:0] timing_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            timing_q <= TIMING_RESET;
        end else if (wr_en) begin
            timing_q <= wr_data;
        end
    end

    // One device view per half of the word
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev_half
        assign dev_tim[d] = dev_timing_t'(timing_q[d*HALF_W +: HALF_W]);
    end

    assert_reset_value_R2: assert property (@(posedge clk)
        $past(rst) |-> (timing_q == TIMING_RESET));

    assert_write_lands_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en)) |-> (timing_q == $past(wr_data)));

endmodule

// File: rtl/ide_pio_sequencer.sv
module ide_pio_sequencer
    import ide_pio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  dev_timing_t timing_in,
    output phase_e      phase,
    output logic        strobe_end
);

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    dev_timing_t      tim_q;
    logic             cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            tim_q   <= dev_timing_t'(TIMING_RESET[HALF_W-1:0]);
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        tim_q   <= timing_in;
                        cnt_q   <= phase_load(CNT_W'(timing_in.setup));
                        phase_q <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (cnt_zero) begin
                        cnt_q   <= phase_load(CNT_W'(tim_q.active));
                        phase_q <= PH_ACTIVE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_ACTIVE: begin
                    if (cnt_zero) begin
                        cnt_q   <= phase_load(CNT_W'(tim_q.recov));
                        phase_q <= PH_RECOV;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_RECOV: begin
                    if (cnt_zero) begin
                        phase_q <= PH_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase      = phase_q;
    assign strobe_end = (phase_q == PH_ACTIVE) && cnt_zero;

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ACTIVE) |-> (cnt_q <= phase_load(CNT_W'(tim_q.active))));

    assert_timing_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE && $past(phase_q) != PH_IDLE) |-> $stable(tim_q));

endmodule

// File: rtl/ide_pio_bus_if.sv
module ide_pio_bus_if
    import ide_pio_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int CS_W   = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [DATA_W-1:0] req_wdata,
    input  phase_e            phase,
    input  logic              strobe_end,
    input  logic [DATA_W-1:0] ide_din,
    output logic [ADDR_W-1:0] ide_addr,
    output logic [CS_W-1:0]   ide_cs_n,
    output logic              ide_rd_n,
    output logic              ide_wr_n,
    output logic [DATA_W-1:0] ide_dout,
    output logic              ide_dout_en,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);

    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CS_W-1:0]   cs_q;
    logic [DATA_W-1:0] wdata_q;
    logic              in_cycle;
    logic              strobing;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            cs_q    <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            wr_q    <= req_write;
            addr_q  <= req_addr;
            cs_q    <= req_cs;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= strobe_end && !wr_q;
            if (strobe_end && !wr_q) begin
                rsp_data <= ide_din;
            end
        end
    end

    assign in_cycle    = (phase != PH_IDLE);
    assign strobing    = (phase == PH_ACTIVE);
    assign ide_addr    = addr_q;
    assign ide_cs_n    = in_cycle ? ~cs_q : '1;
    assign ide_rd_n    = !(strobing && !wr_q);
    assign ide_wr_n    = !(strobing && wr_q);
    assign ide_dout    = wdata_q;
    assign ide_dout_en = wr_q && (phase == PH_SETUP || phase == PH_ACTIVE);

    assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_no_drive_read_R7: assert property (@(posedge clk) disable iff (rst)
        !ide_rd_n |-> !ide_dout_en);

    assert_setup_first_R3: assert property (@(posedge clk) disable iff (rst)
        ($fell(ide_rd_n) || $fell(ide_wr_n)) |->
            ($past(ide_cs_n) != '1) && $past(ide_rd_n && ide_wr_n));

    assert_addr_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && $past(phase) != PH_IDLE) |->
            ($stable(ide_addr) && $stable(ide_cs_n)));

endmodule

// File: rtl/ide_pio_strobe_gen.sv
module ide_pio_strobe_gen
    import ide_pio_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int CS_W   = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [REG_W-1:0]  cfg_wr_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic [ADDR_W-1:0] ide_addr,
    output logic [CS_W-1:0]   ide_cs_n,
    output logic              ide_rd_n,
    output logic              ide_wr_n,
    output logic [DATA_W-1:0] ide_dout,
    output logic              ide_dout_en,
    input  logic [DATA_W-1:0] ide_din,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);

    dev_timing_t [NUM_DEV-1:0] dev_tim;
    dev_timing_t               sel_tim;
    phase_e                    phase;
    logic                      strobe_end;
    logic                      accept;

    ide_pio_timing_reg u_timing (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .dev_tim (dev_tim)
    );

    assign sel_tim   = dev_tim[req_dev];
    assign req_ready = (phase == PH_IDLE);
    assign busy      = !req_ready;
    assign accept    = req_valid && req_ready;

    ide_pio_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (accept),
        .timing_in  (sel_tim),
        .phase      (phase),
        .strobe_end (strobe_end)
    );

    ide_pio_bus_if #(
        .ADDR_W (ADDR_W),
        .CS_W   (CS_W),
        .DATA_W (DATA_W)
    ) u_bus (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_cs      (req_cs),
        .req_wdata   (req_wdata),
        .phase       (phase),
        .strobe_end  (strobe_end),
        .ide_din     (ide_din),
        .ide_addr    (ide_addr),
        .ide_cs_n    (ide_cs_n),
        .ide_rd_n    (ide_rd_n),
        .ide_wr_n    (ide_wr_n),
        .ide_dout    (ide_dout),
        .ide_dout_en (ide_dout_en),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data)
    );

    assert_accept_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> busy);

endmodule

// File: tb/ide_pio_strobe_gen_tb.sv
module ide_pio_strobe_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [0:0]  req_dev = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [1:0]  req_cs = '0;
    logic [15:0] req_wdata = '0;
    logic        busy;
    logic [2:0]  ide_addr;
    logic [1:0]  ide_cs_n;
    logic        ide_rd_n;
    logic        ide_wr_n;
    logic [15:0] ide_dout;
    logic        ide_dout_en;
    logic [15:0] ide_din = '0;
    logic        rsp_valid;
    logic [15:0] rsp_data;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    ide_pio_strobe_gen dut_i (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_dev(req_dev), .req_addr(req_addr), .req_cs(req_cs), .req_wdata(req_wdata),
        .busy(busy), .ide_addr(ide_addr), .ide_cs_n(ide_cs_n), .ide_rd_n(ide_rd_n),
        .ide_wr_n(ide_wr_n), .ide_dout(ide_dout), .ide_dout_en(ide_dout_en),
        .ide_din(ide_din), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [31:0] v);
        wait_idle();
        cfg_wr_en   = 1'b1;
        cfg_wr_data = v;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    // One full transfer, measuring each phase at the pins
    task automatic run_xfer(input bit wr, input bit dev, input logic [2:0] addr,
                            input logic [1:0] cs, input logic [15:0] wd,
                            input logic [15:0] rdv, input int es, input int ea,
                            input int er, input bit cfg_mid, input logic [31:0] cfgv,
                            input string req);
        int ns = 0, na = 0, nr = 0, nv = 0, i = 0;
        bit seen = 0;
        bit slow;
        bit other_low;
        wait_idle();
        req_write = wr; req_dev = dev; req_addr = addr; req_cs = cs;
        req_wdata = wd; ide_din = rdv; req_valid = 1'b1;
        check(req, "ready before accept (R8)", {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        while (busy && i < 500) begin
            if (cfg_mid && i == 1) begin cfg_wr_en = 1'b1; cfg_wr_data = cfgv; end
            if (cfg_mid && i == 2) cfg_wr_en = 1'b0;
            slow      = wr ? !ide_wr_n : !ide_rd_n;
            other_low = wr ? !ide_rd_n : !ide_wr_n;
            if (slow) begin na++; seen = 1; end
            else if (!seen) ns++;
            else nr++;
            check("R10", "other strobe idle", {31'd0, other_low}, 32'd0);
            check("R10", "cs_n held", {30'd0, ide_cs_n}, {30'd0, ~cs});
            check("R10", "addr held", {29'd0, ide_addr}, {29'd0, addr});
            check("R7", "dout_en", {31'd0, ide_dout_en}, {31'd0, wr && (!seen || slow)});
            if (ide_dout_en) check("R7", "dout value", {16'd0, ide_dout}, {16'd0, wd});
            if (rsp_valid) begin
                nv++;
                check("R6", "rsp in first recovery cycle",
                      {31'd0, seen && !slow && nr == 1}, 32'd1);
                check("R6", "rsp data", {16'd0, rsp_data}, {16'd0, rdv});
            end
            if (seen && !slow && nr == 1) ide_din = ~rdv;
            i++;
            @(negedge clk);
        end
        check(req, "setup cycles (R3)", ns, es);
        check(req, "active cycles (R3)", na, ea);
        check(req, "recovery cycles (R3)", nr, er);
        check("R6", "rsp pulses", nv, wr ? 0 : 1);
        check("R10", "cs_n idle after", {30'd0, ide_cs_n}, 32'd3);
    endtask

    task automatic t_reset();
        check("R1", "busy", {31'd0, busy}, 32'd0);
        check("R1", "ready", {31'd0, req_ready}, 32'd1);
        check("R1", "rd_n", {31'd0, ide_rd_n}, 32'd1);
        check("R1", "wr_n", {31'd0, ide_wr_n}, 32'd1);
        check("R1", "cs_n", {30'd0, ide_cs_n}, 32'd3);
        check("R1", "dout_en", {31'd0, ide_dout_en}, 32'd0);
        check("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic t_reset_timing();
        run_xfer(0, 0, 3'd7, 2'b01, 16'h0, 16'hA5C3, 6, 11, 29, 0, 0, "R2 dev0 read");
        run_xfer(1, 1, 3'd2, 2'b10, 16'h1234, 16'h0, 6, 11, 29, 0, 0, "R2 dev1 write");
    endtask

    task automatic t_per_device();
        // dev1: setup 3 active 5 recov 2; dev0: setup 2 active 4 recov 7
        write_cfg(32'h3142_2107);
        run_xfer(0, 1, 3'd1, 2'b01, 16'h0, 16'h5A5A, 3, 5, 2, 0, 0, "R4 dev1 read");
        run_xfer(1, 0, 3'd6, 2'b10, 16'hBEEF, 16'h0, 2, 4, 7, 0, 0, "R4 dev0 write");
        run_xfer(1, 1, 3'd3, 2'b01, 16'hCAFE, 16'h0, 3, 5, 2, 0, 0, "R4 dev1 write");
    endtask

    task automatic t_zero();
        // dev0 all zero; dev1 setup 0 active 1 recov 0
        write_cfg(32'h0040_0000);
        run_xfer(0, 0, 3'd4, 2'b10, 16'h0, 16'h0F0F, 1, 1, 1, 0, 0, "R5 dev0 read");
        run_xfer(1, 1, 3'd5, 2'b01, 16'h7777, 16'h0, 1, 1, 1, 0, 0, "R5 dev1 write");
    endtask

    task automatic t_mid_write();
        write_cfg(32'h62DD_62DD);
        run_xfer(0, 0, 3'd0, 2'b01, 16'h0, 16'h1357, 6, 11, 29, 1, 32'h3142_2107,
                 "R9 running read");
        run_xfer(0, 0, 3'd0, 2'b01, 16'h0, 16'h2468, 2, 4, 7, 0, 0, "R9 next read");
    endtask

    task automatic t_handshake();
        int acc = 0, gap = 0;
        bit drop = 0;
        write_cfg(32'h0000_0000);
        req_write = 1'b1; req_dev = 1'b0; req_addr = 3'd2; req_cs = 2'b01;
        req_wdata = 16'h4242; req_valid = 1'b1;
        for (int k = 0; k < 20; k++) begin
            check("R8", "ready equals not busy", {31'd0, req_ready}, {31'd0, !busy});
            if (req_valid && req_ready) begin
                acc++;
                if (acc == 2) drop = 1;
            end else if (acc == 1 && busy) begin
                gap++;
            end
            @(negedge clk);
            if (drop) begin req_valid = 1'b0; drop = 0; end
        end
        check("R8", "accepted requests", acc, 2);
        check("R8", "busy cycles between accepts", gap, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_reset_timing();
        t_per_device();
        t_zero();
        t_mid_write();
        t_handshake();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule